// File: doc/BRIEF.md
# Pipelined Complex Multiply-Accumulator

The block takes two streams of complex numbers, one pair of elements per clock, multiplies each pair and adds the complex product into a running sum. Every real and imaginary part is a 16-bit two's-complement fraction with one sign bit and 15 fraction bits, so it covers -1 up to, but not including, +1.

Arithmetic is split over a pipeline. An input register captures the four operand parts. The next step forms the four partial products. The step after that combines them into the real part (rr minus ii) and the imaginary part (ri plus ir). The last step adds this product to a 20-bit accumulator that has a range of -16 to +16. Each combined product is truncated toward minus infinity to 15 fraction bits before it is added.

To start a new sum, the user asserts a synchronous clear on the cycle two clocks after the first pair of the sequence was presented. The accumulator is then zero when the first product reaches it. Sequences are separated by at least one idle cycle. One flag reports two kinds of overflow. The first is a sticky condition that is set when the extended accumulator wraps. The second is a per-cycle condition that is asserted while the sum does not fit the 16-bit output format.

Top module: `cmac_pipe`

## Requirements
- R1: Each product added is re = floor((ar·br − ai·bi)/2^15) and im = floor((ar·bi + ai·br)/2^15), with operands taken as signed 16-bit integers. The accumulator holds the running sum of these products in signed 20-bit form.
- R2: A pair presented at clock edge k is first reflected in the outputs after edge k+3. The outputs do not change because of it at edges k+1 or k+2.
- R3: With a new pair on every cycle, the outputs take a new accumulated value on every cycle.
- R4: A clear sampled at an edge sets both accumulators and the sticky overflow to zero at that edge. The product that arrives at the next edge is added to zero.
- R5: When an addition leaves the signed 20-bit range, the accumulator wraps modulo 2^20 and a sticky overflow is set. The flag remains set until a clear or a reset.
- R6: The overflow output is also high in any cycle in which either accumulator lies outside -32768..32767. This part of the flag is not latched.
- R7: A synchronous reset zeroes the accumulators, the pipeline contents and the sticky overflow. While reset is held, the sums and the overflow read zero.
- R8: Each sum output is the accumulator's bit 19 as the sign bit, followed by accumulator bits 14..0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; every input is sampled on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| clr | input | 1 | Synchronous accumulator clear, active high |
| xr | input | 16 | Real part of the first operand |
| xi | input | 16 | Imaginary part of the first operand |
| yr | input | 16 | Real part of the second operand |
| yi | input | 16 | Imaginary part of the second operand |
| sum_re | output | 16 | Real part of the accumulated sum |
| sum_im | output | 16 | Imaginary part of the accumulated sum |
| ovf | output | 1 | Overflow: sticky range wrap or per-cycle output range |

## Verification
A product reaches the sums three edges after its pair is sampled. A clear takes effect at the edge that samples it, and the sticky flag changes at the same edge as the accumulator that caused it. The bench's reference model keeps the last two sampled pairs and one pending product in integer form. At each rising edge it applies clear, adds the pending product and shifts its queue, in the same order the edges deliver them. Outputs are compared with the model at every falling edge, so each result is checked in exactly the cycle it is due and in the cycles before it, when it must not yet show.

// File: rtl/cmac_pipe.sv
module cmac_pipe #(
  parameter int DW = 16,
  parameter int IW = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 clr,
  input  logic signed [DW-1:0] xr,
  input  logic signed [DW-1:0] xi,
  input  logic signed [DW-1:0] yr,
  input  logic signed [DW-1:0] yi,
  output logic        [DW-1:0] sum_re,
  output logic        [DW-1:0] sum_im,
  output logic                 ovf
);
  localparam int FB = DW - 1;
  localparam int AW = DW + IW;
  localparam int PW = 2 * DW;
  localparam int CW = PW + 1;

  logic signed [DW-1:0] xr_q, xi_q, yr_q, yi_q;
  logic signed [PW-1:0] p_rr, p_ii, p_ri, p_ir;
  logic signed [AW-1:0] cre_q, cim_q;
  logic signed [AW-1:0] acc_re, acc_im;
  logic                 ovf_stk;

  wire signed [CW-1:0] cre_w = CW'(p_rr) - CW'(p_ii);
  wire signed [CW-1:0] cim_w = CW'(p_ri) + CW'(p_ir);
  wire signed [AW-1:0] cre_t = AW'($signed(cre_w[CW-1:FB]));
  wire signed [AW-1:0] cim_t = AW'($signed(cim_w[CW-1:FB]));

  wire signed [AW:0] nre = {acc_re[AW-1], acc_re} + {cre_q[AW-1], cre_q};
  wire signed [AW:0] nim = {acc_im[AW-1], acc_im} + {cim_q[AW-1], cim_q};
  wire wrap_re = nre[AW] ^ nre[AW-1];
  wire wrap_im = nim[AW] ^ nim[AW-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      xr_q <= '0; xi_q <= '0; yr_q <= '0; yi_q <= '0;
      p_rr <= '0; p_ii <= '0; p_ri <= '0; p_ir <= '0;
      cre_q <= '0; cim_q <= '0;
    end else begin
      xr_q <= xr; xi_q <= xi; yr_q <= yr; yi_q <= yi;
      p_rr <= xr_q * yr_q;
      p_ii <= xi_q * yi_q;
      p_ri <= xr_q * yi_q;
      p_ir <= xi_q * yr_q;
      cre_q <= cre_t;
      cim_q <= cim_t;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      acc_re  <= '0;
      acc_im  <= '0;
      ovf_stk <= 1'b0;
    end else begin
      acc_re <= nre[AW-1:0];
      acc_im <= nim[AW-1:0];
      if (wrap_re || wrap_im) ovf_stk <= 1'b1;
    end
  end

  wire [AW-FB-1:0] top_re = acc_re[AW-1:FB];
  wire [AW-FB-1:0] top_im = acc_im[AW-1:FB];
  wire out_re = !((&top_re) || (~|top_re));
  wire out_im = !((&top_im) || (~|top_im));

  assign sum_re = {acc_re[AW-1], acc_re[FB-1:0]};
  assign sum_im = {acc_im[AW-1], acc_im[FB-1:0]};
  assign ovf    = ovf_stk | out_re | out_im;
endmodule

// File: rtl/cmac_pipe_chk.sv
module cmac_pipe_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          clr,
  input logic [DW-1:0] sum_re,
  input logic [DW-1:0] sum_im,
  input logic          ovf,
  input logic          ovf_stk
);
  p_clear_zero_r4: assert property (@(posedge clk) disable iff (rst)
    clr |=> (sum_re == '0 && sum_im == '0 && !ovf));

  p_reset_zero_r7: assert property (@(posedge clk)
    rst |=> (sum_re == '0 && sum_im == '0 && !ovf));

  p_sticky_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (ovf_stk && !clr) |=> ovf_stk);

  p_sticky_seen_r5: assert property (@(posedge clk) disable iff (rst)
    ovf_stk |-> ovf);

  p_sticky_rise_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(ovf_stk) |-> !$past(clr));
endmodule

bind cmac_pipe cmac_pipe_chk #(.DW(DW)) u_chk (.*);

// File: tb/cmac_pipe_test.sv
module cmac_pipe_test;
  logic clk = 0;
  logic rst = 1;
  logic clr = 0;
  logic signed [15:0] xr = 0, xi = 0, yr = 0, yi = 0;
  logic [15:0] sum_re, sum_im;
  logic ovf;

  int checks = 0, errors = 0;
  string tag = "R7 reset";
  bit started = 0;

  cmac_pipe uut (.clk(clk), .rst(rst), .clr(clr), .xr(xr), .xi(xi), .yr(yr), .yi(yi),
                 .sum_re(sum_re), .sum_im(sum_im), .ovf(ovf));

  always #2.5 clk = ~clk;

  localparam longint AMAX = (64'sd1 <<< 19) - 1;
  localparam longint AMIN = -(64'sd1 <<< 19);

  longint d1 [4];
  longint d2 [4];
  longint pre, pim, are, aim;
  bit stk;

  function automatic longint wrap20(longint s);
    longint w = s & ((64'sd1 <<< 20) - 1);
    if (w > AMAX) w = w - (64'sd1 <<< 20);
    return w;
  endfunction

  always @(posedge clk) begin
    longint s;
    started = 1;
    if (rst) begin
      for (int i = 0; i < 4; i++) begin d1[i] = 0; d2[i] = 0; end
      pre = 0; pim = 0; are = 0; aim = 0; stk = 0;
    end else begin
      if (clr) begin
        are = 0; aim = 0; stk = 0;
      end else begin
        s = are + pre; if (s > AMAX || s < AMIN) stk = 1; are = wrap20(s);
        s = aim + pim; if (s > AMAX || s < AMIN) stk = 1; aim = wrap20(s);
      end
      pre = (d2[0] * d2[2] - d2[1] * d2[3]) >>> 15;
      pim = (d2[0] * d2[3] + d2[1] * d2[2]) >>> 15;
      for (int i = 0; i < 4; i++) d2[i] = d1[i];
      d1[0] = xr; d1[1] = xi; d1[2] = yr; d1[3] = yi;
    end
  end

  always @(negedge clk) begin
    logic [19:0] ta, tb;
    logic [15:0] ere, eim;
    logic eo;
    if (started) begin
      ta = are[19:0]; tb = aim[19:0];
      ere = {ta[19], ta[14:0]};
      eim = {tb[19], tb[14:0]};
      eo = stk || are > 32767 || are < -32768 || aim > 32767 || aim < -32768;
      checks++;
      if (sum_re !== ere || sum_im !== eim || ovf !== eo) begin
        errors++;
        $display("FAIL %s: re %h exp %h, im %h exp %h, ovf %b exp %b",
                 tag, sum_re, ere, sum_im, eim, ovf, eo);
      end
    end
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: cycles %0d exp below 20000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic step(input int a, input int b, input int c, input int d, input bit cl);
    @(negedge clk);
    xr = 16'(a); xi = 16'(b); yr = 16'(c); yi = 16'(d); clr = cl;
    @(posedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;

    tag = "R2 latency R1";
    step(16384, 0, 16384, 0, 0);
    idle(5);

    tag = "R3 stream R1";
    step(1000, -2000, 3000, 4000, 0);
    step(-12345, 23456, 7777, -30000, 0);
    step(32767, 32767, 32767, -32768, 1);
    step(-5, 9, 11, -13, 0);
    step(20000, -20000, -20000, 20000, 0);
    step(-32768, -32768, -32768, -32768, 0);
    step(123, 456, -789, 321, 0);
    step(-1, -1, 1, 1, 0);
    idle(5);

    tag = "R4 clear";
    step(0, 0, 0, 0, 1);
    idle(3);

    tag = "R5 R8 sticky wrap";
    for (int i = 0; i < 20; i++) step(-32768, 0, -32768, 0, i == 2);
    idle(6);

    tag = "R4 clear after sticky";
    step(0, 0, 0, 0, 1);
    idle(3);

    tag = "R6 per-cycle range";
    step(-32768, 0, -32768, 0, 0);
    step(-32768, 0, 32767, 0, 0);
    step(0, 0, 0, 0, 1);
    idle(5);

    tag = "R1 imaginary";
    step(0, 32767, 0, 32767, 0);
    step(10000, 0, 0, -10000, 0);
    step(0, 0, 0, 0, 1);
    idle(5);

    tag = "R7 reset midrun";
    step(16384, 16384, 16384, 16384, 0);
    idle(4);
    @(negedge clk); rst = 1;
    repeat (2) @(posedge clk);
    @(negedge clk); rst = 0;
    idle(4);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule